// File: doc/BRIEF.md
# Triangular Spread-Spectrum Modulation Controller

This block steers a fractional feedback divider so that a synthesized clock sweeps symmetrically above and below its nominal frequency. Every reference cycle it produces a signed offset word that traces a triangle around zero. The triangle has a fixed length in reference cycles, and its height is one of nine peak deviations. The result spreads the energy of the clock over a band, which lowers peak electromagnetic emissions. The analog loop, the oscillator, the sensing of the three-level pins and the output drivers are all outside this block.

A two-bit range code sets the sweep length and the output multiplier that the divider must apply. Two three-level selectors pick the peak deviation. An enable input starts and stops the sweep. Valid configuration changes wait for the next period boundary, so no sweep is ever cut short. Disabling the sweep, or applying an illegal code, stops it at once with the offset at zero. When modulation resumes, a fresh period starts from zero on a rising ramp.

Top module: `ssm_triangle_mod`

## Requirements
- R1: The interval between period-start pulses is 1166 reference cycles for range codes 00 and 10, and 2332 cycles for range code 01. Call the half length H = period/2.
- R2: Range code 11, or the code 11 on either spread selector, raises `cfg_err` and forces `offset` to 0 from the next cycle on. Once the codes are legal again, `cfg_err` clears and a new period starts on the following cycle.
- R3: Let t be the cycle index since the period-start pulse (t = 0 at the pulse) and Hh = H/2 rounded down. Define the position p(t) as:
  - p(t) = t for t ≤ Hh;
  - p(t) = H − t for Hh < t ≤ H + Hh;
  - p(t) = t − 2H otherwise.

  The offset is `offset` = (2·peak·p(t))/H, with the division truncating toward zero. The curve is therefore centred on zero and symmetric.
- R4: `dir_up` is high when t ≤ Hh or t > H + Hh. It is therefore high for exactly H cycles of each period, starting at the pulse.
- R5: The peak in offset units is PEAK_TENTHS[3·hi + lo] · UNITS_PER_TENTH. Selector codes are 00 = low (0), 01 = middle (1) and 10 = high (2). The default table in tenths of a percent is {9,12,15,19,23,27,31,36,42}, and the default is 64 units per tenth. `offset` never exceeds the peak in magnitude. With an even H (range 01) it reaches exactly +peak and −peak.
- R6: While `mod_en` is low, `offset` is 0, `dir_up` is low and no period-start pulse occurs, from the cycle after `mod_en` falls.
- R7: The cycle after `mod_en` returns high with legal codes, `period_start` pulses, `offset` is 0 and `dir_up` is high.
- R8: A legal change of range or spread codes in mid-period leaves the current period unchanged. The change takes effect from the next period-start pulse.
- R9: `mult_2x` is 1 exactly when the range in use is 01. It changes only together with a period-start pulse.
- R10: During reset, `offset` is 0 and `dir_up`, `period_start`, `cfg_err` and `mult_2x` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| range_code | input | 2 | Sweep length and multiplier select (11 is illegal) |
| spread_lo | input | 2 | Low-order three-level spread selector (00/01/10) |
| spread_hi | input | 2 | High-order three-level spread selector (00/01/10) |
| mod_en | input | 1 | Modulation enable, high runs the sweep |
| offset | output | OFS_W (16) | Signed frequency-offset word for the divider |
| dir_up | output | 1 | High while the ramp is rising |
| period_start | output | 1 | One-cycle pulse at the start of each period |
| cfg_err | output | 1 | Illegal range or selector code present |
| mult_2x | output | 1 | Active range asks for a 2x output multiplier |

## Verification
The bench compares every sample of whole periods against the truncated triangle formula, for both sweep lengths. The odd half length of 583 needs a two-cycle flat top, and a design that miscounts it would drift away from zero by the end of the period. On the even length the exact ±peak values are checked, which exposes a step or remainder error that leaves the crest one unit short or long. A spread change made in mid-period is watched sample by sample: a design that picked it up early would bend the current triangle and misstate `mult_2x`. The tests of disable and illegal codes look for a residual offset, for a missing restart pulse, and for an error flag that sticks or fails to clear.

// File: rtl/ssm_pkg.sv
// Shared definitions for the triangular modulation controller.
// Assumes three-level inputs arrive already digitised as 2-bit codes.
package ssm_pkg;

    localparam int NUM_SETTINGS = 9;

    localparam logic [1:0] RNG_SHORT_A = 2'b00;
    localparam logic [1:0] RNG_LONG    = 2'b01;
    localparam logic [1:0] RNG_SHORT_B = 2'b10;
    localparam logic [1:0] RNG_BAD     = 2'b11;

    localparam logic [1:0] LVL_BAD     = 2'b11;

    typedef int unsigned peak_tab_t [NUM_SETTINGS];

    // True when a three-level code is one of low, middle or high.
    function automatic logic level_ok(input logic [1:0] code);
        return code != LVL_BAD;
    endfunction

endpackage

// File: rtl/ssm_cfg_decode.sv
// Configuration decoder and holding registers.
// Checks the live codes, looks up the per-setting peak and the per-cycle
// quotient/remainder step for both sweep lengths (computed at elaboration),
// and captures the selection on each period boundary (load).
module ssm_cfg_decode
    import ssm_pkg::*;
#(
    parameter int        OFS_W           = 16,
    parameter int        PH_W            = 12,
    parameter int        HALF_SHORT      = 583,
    parameter int        HALF_LONG       = 1166,
    parameter int        UNITS_PER_TENTH = 64,
    parameter peak_tab_t PEAK_TENTHS     = '{9, 12, 15, 19, 23, 27, 31, 36, 42}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       range_code,
    input  logic [1:0]       spread_lo,
    input  logic [1:0]       spread_hi,
    input  logic             load,
    output logic             cfg_ok,
    output logic             act_long,
    output logic             act_mult2,
    output logic [OFS_W-1:0] act_peak,
    output logic [OFS_W-1:0] act_qs,
    output logic [PH_W-1:0]  act_rs
);

    logic [OFS_W-1:0] pk_tab   [NUM_SETTINGS];
    logic [OFS_W-1:0] qs_s_tab [NUM_SETTINGS];
    logic [PH_W-1:0]  rs_s_tab [NUM_SETTINGS];
    logic [OFS_W-1:0] qs_l_tab [NUM_SETTINGS];
    logic [PH_W-1:0]  rs_l_tab [NUM_SETTINGS];

    // Constant tables: peak and the split of 2*peak into H-sized steps.
    for (genvar gi = 0; gi < NUM_SETTINGS; gi++) begin : g_tab
        localparam int PK = int'(PEAK_TENTHS[gi]) * UNITS_PER_TENTH;
        assign pk_tab[gi]   = OFS_W'(PK);
        assign qs_s_tab[gi] = OFS_W'((2 * PK) / HALF_SHORT);
        assign rs_s_tab[gi] = PH_W'((2 * PK) % HALF_SHORT);
        assign qs_l_tab[gi] = OFS_W'((2 * PK) / HALF_LONG);
        assign rs_l_tab[gi] = PH_W'((2 * PK) % HALF_LONG);
    end

    logic [3:0] idx;
    logic [3:0] idx_use;
    logic       live_long;

    // Legality and table index from the live codes.
    always_comb begin
        cfg_ok    = (range_code != RNG_BAD) && level_ok(spread_lo) && level_ok(spread_hi);
        idx       = {2'b00, spread_hi} * 4'd3 + {2'b00, spread_lo};
        idx_use   = cfg_ok ? idx : 4'd0;
        live_long = (range_code == RNG_LONG);
    end

    // Capture the live selection at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_long  <= 1'b0;
            act_mult2 <= 1'b0;
            act_peak  <= '0;
            act_qs    <= '0;
            act_rs    <= '0;
        end else if (load) begin
            act_long  <= live_long;
            act_mult2 <= live_long;
            act_peak  <= pk_tab[idx_use];
            act_qs    <= live_long ? qs_l_tab[idx_use] : qs_s_tab[idx_use];
            act_rs    <= live_long ? rs_l_tab[idx_use] : rs_s_tab[idx_use];
        end
    end

endmodule

// File: rtl/ssm_phase.sv
// Period sequencer.
// Counts the cycle index t within a period of 2*H, tracks the triangle
// position p(t) and emits the per-cycle step direction for the accumulator.
// Assumes go already folds in enable and code legality.
module ssm_phase #(
    parameter int HALF_SHORT = 583,
    parameter int HALF_LONG  = 1166,
    parameter int PH_W       = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            act_long,
    output logic            run,
    output logic            boundary,
    output logic            step_up,
    output logic            step_dn,
    output logic            dir_up,
    output logic            period_start,
    output logic [PH_W-1:0] half_len
);

    // Triangle position for cycle index tt of a period with half length hv.
    function automatic int tri_pos(input int tt, input int hv);
        int hh;
        hh = hv / 2;
        if (tt <= hh)           return tt;
        else if (tt <= hv + hh) return hv - tt;
        else                    return tt - 2 * hv;
    endfunction

    logic                   run_q;
    logic [PH_W-1:0]        t_q;
    logic signed [PH_W:0]   tri_q;
    logic [PH_W-1:0]        t_n;
    logic signed [PH_W:0]   tri_n;
    logic                   wrap;
    int                     half_i;
    int                     hh_i;
    int                     t_i;

    // Next index and next triangle position.
    always_comb begin
        half_i = act_long ? HALF_LONG : HALF_SHORT;
        hh_i   = half_i / 2;
        t_i    = int'(t_q);
        wrap   = (t_i == 2 * half_i - 1);
        t_n    = wrap ? '0 : t_q + 1'b1;
        tri_n  = (PH_W+1)'(tri_pos(int'(t_n), half_i));
    end

    // Run flag, index and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            run_q <= 1'b0;
            t_q   <= '0;
            tri_q <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            t_q   <= '0;
            tri_q <= '0;
        end else begin
            t_q   <= t_n;
            tri_q <= tri_n;
        end
    end

    // Derived controls and status.
    always_comb begin
        run          = run_q;
        boundary     = go && (!run_q || wrap);
        step_up      = go && run_q && (tri_n > tri_q);
        step_dn      = go && run_q && (tri_n < tri_q);
        dir_up       = run_q && ((t_i <= hh_i) || (t_i > half_i + hh_i));
        period_start = run_q && (t_q == '0);
        half_len     = PH_W'(half_i);
    end

endmodule

// File: rtl/ssm_ramp_accum.sv
// Offset accumulator.
// Holds 2*peak*p as quotient q and remainder r over H, moving one
// position per step, and outputs q truncated toward zero.
// Assumes the step constants stay fixed except at p = 0.
module ssm_ramp_accum #(
    parameter int OFS_W = 16,
    parameter int PH_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    step_up,
    input  logic                    step_dn,
    input  logic [OFS_W-1:0]        qs,
    input  logic [PH_W-1:0]         rs,
    input  logic [PH_W-1:0]         half_len,
    output logic signed [OFS_W-1:0] offset
);

    localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

    logic signed [OFS_W-1:0] q_q;
    logic signed [OFS_W-1:0] q_n;
    logic signed [OFS_W-1:0] qs_e;
    logic [PH_W-1:0]         r_q;
    logic [PH_W-1:0]         r_n;
    logic [PH_W:0]           r_sum;
    logic signed [PH_W+1:0]  r_dif;

    // Next quotient and remainder for one position step.
    always_comb begin
        qs_e  = $signed(qs);
        r_sum = {1'b0, r_q} + {1'b0, rs};
        r_dif = $signed({2'b00, r_q}) - $signed({2'b00, rs});
        q_n   = q_q;
        r_n   = r_q;
        if (step_up) begin
            if (r_sum >= {1'b0, half_len}) begin
                r_n = PH_W'(r_sum - {1'b0, half_len});
                q_n = q_q + qs_e + ONE;
            end else begin
                r_n = PH_W'(r_sum);
                q_n = q_q + qs_e;
            end
        end else if (step_dn) begin
            if (r_dif < 0) begin
                r_n = PH_W'(r_dif + $signed({2'b00, half_len}));
                q_n = q_q - qs_e - ONE;
            end else begin
                r_n = PH_W'(r_dif);
                q_n = q_q - qs_e;
            end
        end
    end

    // Accumulator registers, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            q_q <= '0;
            r_q <= '0;
        end else begin
            q_q <= q_n;
            r_q <= r_n;
        end
    end

    // Truncate toward zero so both halves are mirror images.
    assign offset = ((q_q < 0) && (r_q != '0)) ? q_q + ONE : q_q;

endmodule

// File: rtl/ssm_triangle_mod.sv
// Top of the triangular spread-spectrum modulation controller.
// Joins decoder, sequencer and accumulator; registers the error flag.
// Assumes all inputs are synchronous to clk.
module ssm_triangle_mod
    import ssm_pkg::*;
#(
    parameter int        OFS_W           = 16,
    parameter int        PERIOD_SHORT    = 1166,
    parameter int        PERIOD_LONG     = 2332,
    parameter int        UNITS_PER_TENTH = 64,
    parameter peak_tab_t PEAK_TENTHS     = '{9, 12, 15, 19, 23, 27, 31, 36, 42}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              range_code,
    input  logic [1:0]              spread_lo,
    input  logic [1:0]              spread_hi,
    input  logic                    mod_en,
    output logic signed [OFS_W-1:0] offset,
    output logic                    dir_up,
    output logic                    period_start,
    output logic                    cfg_err,
    output logic                    mult_2x
);

    localparam int HALF_SHORT = PERIOD_SHORT / 2;
    localparam int HALF_LONG  = PERIOD_LONG / 2;
    localparam int PH_W       = $clog2(PERIOD_LONG);

    logic             cfg_ok;
    logic             go;
    logic             run;
    logic             boundary;
    logic             step_up;
    logic             step_dn;
    logic             act_long;
    logic [OFS_W-1:0] act_peak;
    logic [OFS_W-1:0] act_qs;
    logic [PH_W-1:0]  act_rs;
    logic [PH_W-1:0]  half_len;

    assign go = mod_en && cfg_ok;

    ssm_cfg_decode #(
        .OFS_W(OFS_W), .PH_W(PH_W), .HALF_SHORT(HALF_SHORT), .HALF_LONG(HALF_LONG),
        .UNITS_PER_TENTH(UNITS_PER_TENTH), .PEAK_TENTHS(PEAK_TENTHS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .range_code(range_code), .spread_lo(spread_lo),
        .spread_hi(spread_hi), .load(boundary), .cfg_ok(cfg_ok), .act_long(act_long),
        .act_mult2(mult_2x), .act_peak(act_peak), .act_qs(act_qs), .act_rs(act_rs)
    );

    ssm_phase #(
        .HALF_SHORT(HALF_SHORT), .HALF_LONG(HALF_LONG), .PH_W(PH_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .go(go), .act_long(act_long), .run(run),
        .boundary(boundary), .step_up(step_up), .step_dn(step_dn), .dir_up(dir_up),
        .period_start(period_start), .half_len(half_len)
    );

    ssm_ramp_accum #(
        .OFS_W(OFS_W), .PH_W(PH_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(!(go && run)), .step_up(step_up),
        .step_dn(step_dn), .qs(act_qs), .rs(act_rs), .half_len(half_len), .offset(offset)
    );

    // Error flag follows the live code legality one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= !cfg_ok;
    end

endmodule

// File: rtl/ssm_triangle_mod_chk.sv
// Property checker for ssm_triangle_mod, attached by bind below.
// Assumes act_peak is the peak value held for the running period.
module ssm_triangle_mod_chk #(
    parameter int OFS_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              range_code,
    input logic                    mod_en,
    input logic signed [OFS_W-1:0] offset,
    input logic                    dir_up,
    input logic                    period_start,
    input logic                    cfg_err,
    input logic                    mult_2x,
    input logic [OFS_W-1:0]        act_peak
);

    logic signed [OFS_W:0] pk_s;
    logic signed [OFS_W:0] ofs_s;
    assign pk_s  = $signed({1'b0, act_peak});
    assign ofs_s = $signed({offset[OFS_W-1], offset});

    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (offset == '0) && !dir_up && !period_start);

    a_r2_bad_range: assert property (@(posedge clk) disable iff (!rst_n)
        (range_code == 2'b11) |=> cfg_err && (offset == '0));

    a_r5_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_s <= pk_s) && (ofs_s >= -pk_s));

    a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (offset == '0) && dir_up);

    a_r9_mult_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> $stable(mult_2x));

endmodule

bind ssm_triangle_mod ssm_triangle_mod_chk #(.OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .range_code(range_code), .mod_en(mod_en),
    .offset(offset), .dir_up(dir_up), .period_start(period_start),
    .cfg_err(cfg_err), .mult_2x(mult_2x), .act_peak(act_peak)
);

// File: tb/tb_ssm_triangle_mod.sv
`timescale 1ns/1ps
module tb_ssm_triangle_mod;

    localparam int OFS_W = 16;
    localparam int UNITS = 64;
    localparam int HS    = 583;
    localparam int HL    = 1166;
    localparam int TAB [9] = '{9, 12, 15, 19, 23, 27, 31, 36, 42};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              range_code = 2'b00;
    logic [1:0]              spread_lo = 2'b00;
    logic [1:0]              spread_hi = 2'b00;
    logic                    mod_en = 1'b1;
    logic signed [OFS_W-1:0] offset;
    logic                    dir_up;
    logic                    period_start;
    logic                    cfg_err;
    logic                    mult_2x;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ssm_triangle_mod dut (
        .clk(clk), .rst_n(rst_n), .range_code(range_code), .spread_lo(spread_lo),
        .spread_hi(spread_hi), .mod_en(mod_en), .offset(offset), .dir_up(dir_up),
        .period_start(period_start), .cfg_err(cfg_err), .mult_2x(mult_2x)
    );

    function automatic int peak_of(input int idx);
        return TAB[idx] * UNITS;
    endfunction

    function automatic int exp_ofs(input int t, input int h, input int pk);
        int hh;
        int p;
        hh = h / 2;
        if (t <= hh)         p = t;
        else if (t <= h + hh) p = h - t;
        else                  p = t - 2 * h;
        return (2 * pk * p) / h;
    endfunction

    function automatic bit exp_dir(input int t, input int h);
        return (t <= h / 2) || (t > h + h / 2);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pulse();
        int guard = 0;
        @(negedge clk);
        while (!period_start && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(period_start == 1'b1, "R1", "pulse seen", int'(period_start), 1);
    endtask

    // Walk one whole period from a pulse; ends on the next pulse sample.
    task automatic run_period(input int h, input int pk, output int mx, output int mn);
        int bad_o = 0, bad_d = 0, ups = 0, fa = 0, fe = 0;
        int got;
        mx = -100000;
        mn = 100000;
        for (int t = 0; t < 2 * h; t++) begin
            got = offset;
            if (got != exp_ofs(t, h, pk)) begin
                if (bad_o == 0) begin fa = got; fe = exp_ofs(t, h, pk); end
                bad_o++;
            end
            if (dir_up != exp_dir(t, h)) bad_d++;
            if (dir_up) ups++;
            if (t > 0 && period_start) bad_d++;
            if (got > mx) mx = got;
            if (got < mn) mn = got;
            @(negedge clk);
        end
        check(bad_o == 0, "R3", "triangle samples", fa, fe);
        check(bad_d == 0 && ups == h, "R4", "rising cycles", ups, h);
        check(period_start == 1'b1, "R1", "period length", int'(period_start), 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(offset == 0 && !dir_up && !period_start && !cfg_err && !mult_2x,
              "R10", "reset outputs", int'(offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(period_start && offset == 0 && dir_up, "R7", "first start", int'(period_start), 1);
    endtask

    task automatic t_short_basic();
        int mx, mn;
        run_period(HS, peak_of(0), mx, mn);
        check(mult_2x == 1'b0, "R9", "range 00 multiplier", int'(mult_2x), 0);
    endtask

    task automatic t_long_exact();
        int mx, mn;
        range_code = 2'b01; spread_lo = 2'b10; spread_hi = 2'b10;
        wait_pulse();
        check(mult_2x == 1'b1, "R9", "range 01 multiplier", int'(mult_2x), 1);
        run_period(HL, peak_of(8), mx, mn);
        check(mx == peak_of(8), "R5", "top of long sweep", mx, peak_of(8));
        check(mn == -peak_of(8), "R5", "bottom of long sweep", mn, -peak_of(8));
    endtask

    task automatic t_range10();
        int mx, mn;
        range_code = 2'b10; spread_lo = 2'b01; spread_hi = 2'b00;
        wait_pulse();
        check(mult_2x == 1'b0, "R9", "range 10 multiplier", int'(mult_2x), 0);
        run_period(HS, peak_of(1), mx, mn);
        check(mx <= peak_of(1) && mn >= -peak_of(1), "R5", "odd half bound", mx, peak_of(1));
    endtask

    task automatic t_mid_change();
        int bad = 0, fa = 0, fe = 0, got, mx, mn;
        for (int t = 0; t < 2 * HS; t++) begin
            if (t == 300) begin
                range_code = 2'b01; spread_lo = 2'b10; spread_hi = 2'b01;
            end
            got = offset;
            if (got != exp_ofs(t, HS, peak_of(1)) || mult_2x || (t > 0 && period_start)) begin
                if (bad == 0) begin fa = got; fe = exp_ofs(t, HS, peak_of(1)); end
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, "R8", "old setting kept to boundary", fa, fe);
        check(period_start && mult_2x, "R8", "new setting at boundary", int'(mult_2x), 1);
        run_period(HL, peak_of(5), mx, mn);
    endtask

    task automatic t_disable();
        int bad = 0;
        repeat (50) @(negedge clk);
        mod_en = 1'b0;
        @(negedge clk);
        check(offset == 0 && !dir_up && !period_start, "R6", "stop next cycle", int'(offset), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (offset != 0 || period_start || dir_up) bad++;
        end
        check(bad == 0, "R6", "held at zero", bad, 0);
        mod_en = 1'b1;
        @(negedge clk);
        check(period_start && offset == 0 && dir_up, "R7", "restart pulse", int'(offset), 0);
        @(negedge clk);
        check(int'(offset) == exp_ofs(1, HL, peak_of(5)), "R7", "rising after restart",
              int'(offset), exp_ofs(1, HL, peak_of(5)));
    endtask

    task automatic t_invalid();
        int bad = 0;
        repeat (40) @(negedge clk);
        range_code = 2'b11;
        @(negedge clk);
        check(cfg_err && offset == 0, "R2", "bad range flagged", int'(cfg_err), 1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!cfg_err || offset != 0 || period_start) bad++;
        end
        check(bad == 0, "R2", "held while bad", bad, 0);
        range_code = 2'b00;
        @(negedge clk);
        check(!cfg_err && period_start && offset == 0, "R2", "recovery", int'(cfg_err), 0);
        repeat (30) @(negedge clk);
        spread_lo = 2'b11;
        @(negedge clk);
        check(cfg_err && offset == 0, "R2", "bad selector flagged", int'(offset), 0);
        spread_lo = 2'b00;
        @(negedge clk);
        check(!cfg_err && period_start, "R2", "selector recovery", int'(cfg_err), 0);
    endtask

    initial begin
        t_reset();
        t_short_basic();
        t_long_exact();
        t_range10();
        t_mid_change();
        t_disable();
        t_invalid();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule